// File: doc/BRIEF.md
# Flow-Through Late-Write Synchronous SRAM

This block is a synchronous static memory for a shared data bus. Commands (read, write, deselect), the address and the per-byte write strobes are registered on the rising clock edge. Read data has no output register. Once a read is registered, the word flows from the array to the data-out port within that same cycle, and it stays there for as long as the registers hold.

Writes use a late-write protocol. The command and address are taken on one enabled edge, and the write data on the next enabled edge. Captured data sits in a one-entry write buffer until the following enabled edge, when it is committed to the array. A read of that address in the meantime is served from the buffer, byte by byte. Because write data arrives one cycle after its command, reads and writes can be interleaved on consecutive cycles with no idle cycles. Data-in and data-out are never used in the same cycle.

A clock-enable input freezes every register, including a pending write. A burst input makes the block use the previous registered address plus one instead of the address pins.

Top module: `ftlw_sram`

## Requirements
- R1: After a synchronous reset, no operation is pending. `dout_en` is 0 and `dout` is 0 until a read is registered.
- R2: A selected read (`cs`=1, `we`=0) registered on an enabled edge makes `dout` equal the stored word at that address in the same cycle, with `dout_en`=1 while `oe_n`=0. There is no extra pipeline stage.
- R3: While `cke`=0, clock edges change no state. A registered read keeps `dout` valid, and a pending write is held until the next enabled edge, where its data is captured.
- R4: `oe_n`=1 forces `dout` to 0 and `dout_en` to 0, without waiting for a clock edge.
- R5: A selected write (`cs`=1, `we`=1) registers the address and `be_n`. `din` is captured on the next enabled edge. Byte i (`din[8i+7:8i]`) is written only when `be_n[i]`=0. Other bytes keep their old value.
- R6: In the cycle after a registered write or deselect, `dout_en` is 0 whatever `oe_n` is, so the bus is free for write data.
- R7: Any sequence of reads and writes on consecutive enabled edges is accepted. A read of a word whose data was captured on the same edge returns the new bytes merged with the old ones (forwarding).
- R8: With `burst`=1 on a selected command, the address used is the previous registered address plus one, modulo the depth (63 wraps to 0). `addr` is ignored.
- R9: A deselect (`cs`=0) writes nothing, and it leaves the registered address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge captures inputs |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable, active high |
| cs | input | 1 | Select; 0 is a deselect (no operation) |
| we | input | 1 | 1 = write, 0 = read (when selected) |
| burst | input | 1 | 1 = use previous address plus one |
| addr | input | AW (6) | Word address |
| be_n | input | NB (2) | Active-low byte write strobes |
| din | input | NB*8 (16) | Write data, sampled one enabled edge after its command |
| oe_n | input | 1 | Active-low output enable |
| dout | output | NB*8 (16) | Read data (0 when not driven) |
| dout_en | output | 1 | High when `dout` carries read data |

## Verification
The bench goes after the following corner cases:

- **Read of a word whose data was captured on that same edge, with partial byte strobes.** A design without byte-wise forwarding returns the stale word, or overwrites bytes that were masked.
- **A pending write held across clock-enable-low cycles.** A design that samples data-in during a disabled cycle stores garbage.
- **A design that lets the output drift** would lose read data during the same disabled cycles.
- **Burst addressing wrapping from the last word to word 0.** Wrong wrapping corrupts the burst.
- **Deselects between commands, and an output enable toggled mid-cycle.** These expose a design that writes on a deselect, or that drives the bus in the data cycle of a write.

// File: rtl/ftlw_pkg.sv
package ftlw_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    function automatic op_e op_decode(input logic sel, input logic wr);
        if (!sel)    return OP_IDLE;
        else if (wr) return OP_WRITE;
        else         return OP_READ;
    endfunction

endpackage

// File: rtl/ftlw_ctrl.sv
module ftlw_ctrl
    import ftlw_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cke,
    input  logic          cs,
    input  logic          we,
    input  logic          burst,
    input  logic [AW-1:0] addr,
    input  logic [NB-1:0] be_n,
    output op_e           op_q,
    output logic [AW-1:0] addr_q,
    output logic [NB-1:0] be_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
            be_q   <= '1;
        end else if (cke) begin
            op_q <= op_decode(cs, we);
            if (cs) begin
                addr_q <= burst ? addr_q + 1'b1 : addr;
                be_q   <= be_n;
            end
        end
    end

    // R3: disabled edges leave the command registers untouched
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !cke |=> ($stable(op_q) && $stable(addr_q) && $stable(be_q)));

    // R8: burst advances the registered address by one, wrapping
    p_burst_r8: assert property (@(posedge clk) disable iff (rst)
        (cke && cs && burst) |=> (addr_q == AW'($past(addr_q) + 1'b1)));

    // R9: deselect keeps the address register
    p_desel_r9: assert property (@(posedge clk) disable iff (rst)
        (cke && !cs) |=> $stable(addr_q));

endmodule

// File: rtl/ftlw_wbuf.sv
module ftlw_wbuf
    import ftlw_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int BW = 8,
    localparam int DW = NB * BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cke,
    input  op_e           op_q,
    input  logic [AW-1:0] addr_q,
    input  logic [NB-1:0] be_q,
    input  logic [DW-1:0] din,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr,
    output logic [NB-1:0] wb_be_n,
    output logic [DW-1:0] wb_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_addr  <= '0;
            wb_be_n  <= '1;
            wb_data  <= '0;
        end else if (cke) begin
            wb_valid <= (op_q == OP_WRITE);
            if (op_q == OP_WRITE) begin
                wb_addr <= addr_q;
                wb_be_n <= be_q;
                wb_data <= din;
            end
        end
    end

    // R5: late-write data is taken on the enabled edge after the command
    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (cke && op_q == OP_WRITE) |=>
            (wb_valid && wb_data == $past(din) && wb_addr == $past(addr_q)));

    // R3: a disabled edge neither captures nor drops buffered data
    p_wbhold_r3: assert property (@(posedge clk) disable iff (rst)
        !cke |=> ($stable(wb_valid) && $stable(wb_data)));

endmodule

// File: rtl/ftlw_array.sv
module ftlw_array #(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int BW = 8,
    localparam int DW    = NB * BW,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [NB-1:0] wr_be_n,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];

    for (genvar b = 0; b < NB; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (wr_en && !wr_be_n[b])
                mem[wr_addr][b*BW +: BW] <= wr_data[b*BW +: BW];
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ftlw_sram.sv
module ftlw_sram
    import ftlw_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int BW = 8,
    localparam int DW = NB * BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cke,
    input  logic          cs,
    input  logic          we,
    input  logic          burst,
    input  logic [AW-1:0] addr,
    input  logic [NB-1:0] be_n,
    input  logic [DW-1:0] din,
    input  logic          oe_n,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [NB-1:0] be_q;
    logic          wb_valid;
    logic [AW-1:0] wb_addr;
    logic [NB-1:0] wb_be_n;
    logic [DW-1:0] wb_data;
    logic [DW-1:0] arr_data;
    logic [DW-1:0] rd_word;
    logic          commit;
    logic          fwd_hit;

    ftlw_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
        .clk(clk), .rst(rst), .cke(cke), .cs(cs), .we(we), .burst(burst),
        .addr(addr), .be_n(be_n), .op_q(op_q), .addr_q(addr_q), .be_q(be_q)
    );

    ftlw_wbuf #(.AW(AW), .NB(NB), .BW(BW)) u_wbuf (
        .clk(clk), .rst(rst), .cke(cke), .op_q(op_q), .addr_q(addr_q),
        .be_q(be_q), .din(din), .wb_valid(wb_valid), .wb_addr(wb_addr),
        .wb_be_n(wb_be_n), .wb_data(wb_data)
    );

    assign commit = cke && wb_valid && !rst;

    ftlw_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
        .clk(clk), .wr_en(commit), .wr_addr(wb_addr), .wr_be_n(wb_be_n),
        .wr_data(wb_data), .rd_addr(addr_q), .rd_data(arr_data)
    );

    assign fwd_hit = wb_valid && (wb_addr == addr_q);

    for (genvar b = 0; b < NB; b++) begin : g_fwd
        assign rd_word[b*BW +: BW] = (fwd_hit && !wb_be_n[b])
                                   ? wb_data[b*BW +: BW]
                                   : arr_data[b*BW +: BW];
    end

    assign dout_en = (op_q == OP_READ) && !oe_n;
    assign dout    = dout_en ? rd_word : '0;

    // R6: no drive while the previous command was not a read
    p_no_contend_r6: assert property (@(posedge clk) disable iff (rst)
        (op_q != OP_READ) |-> !dout_en);

    // R4: output disabled means a quiet bus
    p_oe_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (dout == '0));

    // R2: a registered read with output enabled always drives
    p_flow_r2: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_READ && !oe_n) |-> dout_en);

    // R1: reset leaves nothing pending
    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!wb_valid && !dout_en));

endmodule

// File: tb/ftlw_sram_test.sv
`timescale 1ns/1ps
module ftlw_sram_test;
    localparam int AW = 6, NB = 2, BW = 8, DW = 16, DEPTH = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cke = 1'b1, cs = 1'b0, we = 1'b0, burst = 1'b0, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [NB-1:0] be_n = '1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int checks = 0, errors = 0;

    logic [DW-1:0] mem_m [DEPTH];
    bit            pend = 0, exp_rd = 0;
    logic [AW-1:0] pend_a = '0, last_a = '0, exp_a = '0;
    logic [NB-1:0] pend_be = '1;

    always #4 clk = ~clk;

    ftlw_sram #(.AW(AW), .NB(NB), .BW(BW)) uut (
        .clk(clk), .rst(rst), .cke(cke), .cs(cs), .we(we), .burst(burst),
        .addr(addr), .be_n(be_n), .din(din), .oe_n(oe_n),
        .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [DW-1:0] pat(input int x);
        return DW'(x * 40503 + 7);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_out(input string tag);
        if (exp_rd && !oe_n) begin
            check(dout_en === 1'b1 && dout === mem_m[exp_a], tag,
                  {dout_en, dout[DW-2:0]}, {1'b1, mem_m[exp_a][DW-2:0]});
            check(dout === mem_m[exp_a], tag, dout, mem_m[exp_a]);
        end else begin
            check(dout_en === 1'b0 && dout === '0, tag, {dout_en, dout[DW-2:0]}, '0);
        end
    endtask

    task automatic step(input bit ck, input bit c, input bit w, input bit b,
                        input logic [AW-1:0] a, input logic [NB-1:0] be,
                        input logic [DW-1:0] d, input bit oe, input string tag);
        @(negedge clk);
        cke = ck; cs = c; we = w; burst = b; addr = a; be_n = be; din = d; oe_n = oe;
        if (ck) begin
            if (pend)
                for (int i = 0; i < NB; i++)
                    if (!pend_be[i]) mem_m[pend_a][i*BW +: BW] = d[i*BW +: BW];
            if (c) begin
                last_a  = b ? AW'(last_a + 1'b1) : a;
                exp_a   = last_a;
                exp_rd  = !w;
                pend    = w;
                pend_a  = last_a;
                pend_be = be;
            end else begin
                exp_rd = 0;
                pend   = 0;
            end
        end
        @(posedge clk);
        #1;
        check_out(tag);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(dout_en === 1'b0 && dout === '0, "R1", {dout_en, dout[DW-2:0]}, '0);
        oe_n = 1'b0;
        #1;
        check(dout_en === 1'b0, "R1", {15'd0, dout_en}, '0);

        // R5: fill every word back to back (data one edge after command)
        for (int i = 0; i <= DEPTH; i++)
            step(1, i < DEPTH, 1, 0, AW'(i), 2'b00, pat(i - 1), 0, "R5");

        // R2: read sweep
        for (int i = 0; i < DEPTH; i++)
            step(1, 1, 0, 0, AW'(i), 2'b11, 16'hDEAD, 0, "R2");

        // R4: output enable high, then low, without a clock edge
        step(1, 1, 0, 0, 6'd5, 2'b11, '0, 1, "R4");
        @(negedge clk); oe_n = 1'b0; #1;
        check(dout_en === 1'b1 && dout === mem_m[5], "R4", dout, mem_m[5]);
        oe_n = 1'b1; #1;
        check(dout_en === 1'b0 && dout === '0, "R4", dout, '0);

        // R5/R7: partial write then immediate read (forwarding), then re-read
        step(1, 1, 1, 0, 6'd9, 2'b01, '0, 0, "R6");
        step(1, 1, 0, 0, 6'd9, 2'b11, 16'hBEEF, 0, "R7");
        step(1, 1, 0, 0, 6'd9, 2'b11, '0, 0, "R5");
        step(1, 1, 1, 0, 6'd9, 2'b10, '0, 0, "R6");
        step(1, 1, 0, 0, 6'd9, 2'b11, 16'h1234, 0, "R7");

        // R7: alternating read/write with no idle cycles
        for (int i = 0; i < 24; i++)
            step(1, 1, i[0], 0, AW'(20 + i / 2), 2'b00, pat(i + 500), 0, "R7");

        // R3: pending write held across disabled cycles
        step(1, 1, 1, 0, 6'd30, 2'b00, '0, 0, "R6");
        step(0, 1, 0, 0, 6'd1, 2'b00, 16'h0BAD, 0, "R3");
        step(0, 0, 1, 0, 6'd2, 2'b00, 16'h0BAD, 0, "R3");
        step(1, 1, 0, 0, 6'd30, 2'b11, 16'h5A5A, 0, "R3");
        // R3: read output held while disabled
        step(0, 1, 1, 0, 6'd3, 2'b00, 16'hFFFF, 0, "R3");
        step(0, 0, 0, 0, 6'd4, 2'b00, 16'hFFFF, 0, "R3");
        step(1, 1, 0, 0, 6'd30, 2'b11, '0, 0, "R3");

        // R8: burst writes wrapping 63 -> 0, then burst reads
        step(1, 1, 1, 0, 6'd62, 2'b00, '0, 0, "R8");
        step(1, 1, 1, 1, 6'd7, 2'b00, 16'hA001, 0, "R8");
        step(1, 1, 1, 1, 6'd7, 2'b00, 16'hA002, 0, "R8");
        step(1, 0, 0, 0, 6'd7, 2'b00, 16'hA003, 0, "R8");
        step(1, 1, 0, 0, 6'd62, 2'b11, '0, 0, "R8");
        step(1, 1, 0, 1, 6'd9, 2'b11, '0, 0, "R8");
        step(1, 1, 0, 1, 6'd9, 2'b11, '0, 0, "R8");

        // R9: deselect writes nothing and keeps the address for bursts
        step(1, 0, 1, 0, 6'd3, 2'b00, 16'h7777, 0, "R9");
        step(1, 0, 1, 0, 6'd3, 2'b00, 16'h7777, 0, "R9");
        step(1, 1, 0, 1, 6'd40, 2'b11, 16'h7777, 0, "R9");
        step(1, 1, 0, 0, 6'd3, 2'b11, '0, 0, "R9");

        // R7: random mix of commands, strobes, enables
        for (int i = 0; i < 3000; i++)
            step(($urandom % 5) != 0, ($urandom % 4) != 0, $urandom % 2,
                 ($urandom % 4) == 0, AW'($urandom), NB'($urandom),
                 DW'($urandom), ($urandom % 6) == 0, "R7");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule